// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block is one logic cell of a small reconfigurable array. A static 32-bit configuration word sets its whole behaviour. Four selectors each feed one address bit of a 16-entry lookup table. Each selector can tie its bit to 0 or 1, or pass one of two routing-channel signals. Tying unused address bits to a constant lets the table implement functions of fewer than four variables.

The table result either leaves the cell directly or passes through a rising-edge flip-flop first. The configuration decides which. The flip-flop always clears on the block reset. It can also be set up to clear synchronously on a channel reset signal.

The cell result is offered to four channel tracks. Each track has its own enable bit. Instead of tri-state drivers, each track carries a data bit and a separate enable bit. A disabled track's data bit reads 0.

Top module: `lut_cell`

## Requirements
- R1: The block reset `rst` is synchronous and active high. It clears the flip-flop, so in registered mode the cell result is 0 at the first falling edge after a rising edge where `rst` was high.
- R2: The table result is `cfg_word[idx]`, where `idx = {a3,a2,a1,a0}` and `a0` is the least significant bit. So the table occupies `cfg_word[15:0]`.
- R3: Address bit `ai` (i = 0..3) is selected by `cfg_word[17+2i:16+2i]`, as follows:
  - 00 selects constant 0.
  - 01 selects constant 1.
  - 10 selects `chan_in[2i]`.
  - 11 selects `chan_in[2i+1]`.
- R4: With `cfg_word[24]`=0, the cell result is the combinational table result. With `cfg_word[24]`=1, the cell result is the flip-flop, which loads the table result at every rising clock edge.
- R5: With `cfg_word[25]`=1, a high `chan_rst` at a rising edge clears the flip-flop, and this takes priority over loading. With `cfg_word[25]`=0, `chan_rst` has no effect.
- R6: `track_en[i]` = `cfg_word[26+i]`. `track_data[i]` equals the cell result when `track_en[i]` is 1, and 0 otherwise.
- R7: `cfg_word[31:30]` has no effect on any output.
- R8: Two-input AND configuration:
  - `cfg_word[3:0]`=4'b1000, with any values in the upper table bits.
  - Selectors 2 and 3 set to constant 0.
  - Selectors 0 and 1 set to channel signals.
  - The cell then outputs the AND of those two channel signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high block reset |
| cfg_word | input | 32 | Static configuration word |
| chan_in | input | 8 | Routing-channel signals, two per table input |
| chan_rst | input | 1 | Channel signal usable as the flip-flop reset |
| track_data | output | 4 | Cell result on each track, 0 when the track is disabled |
| track_en | output | 4 | Track enables |

## Verification
A wrong selector decode or a wrong table index shows up at once on every enabled track in combinational mode. The same fault shows up one clock later in registered mode.

A flip-flop that misses a load or a reset, or that reacts to a reset it should ignore, is visible as a wrong value on the tracks in registered mode. The error appears from the first falling edge after the offending rising edge and lasts until the next load.

A stale or crossed enable shows at once as a wrong `track_en` bit, or as data leaking onto a disabled track.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    localparam int LUT_K     = 4;
    localparam int LUT_BITS  = 1 << LUT_K;
    localparam int SEL_W     = 2;
    localparam int N_TRACK   = 4;
    localparam int CHAN_W    = 2 * LUT_K;
    localparam int RSVD_W    = 2;
    localparam int CFG_W     = LUT_BITS + LUT_K * SEL_W + 2 + N_TRACK + RSVD_W;

    typedef enum logic [SEL_W-1:0] {
        SRC_LOW    = 2'b00,
        SRC_HIGH   = 2'b01,
        SRC_CHAN_A = 2'b10,
        SRC_CHAN_B = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic [RSVD_W-1:0]             rsvd;
        logic [N_TRACK-1:0]            oe;
        logic                          rst_from_chan;
        logic                          use_reg;
        logic [LUT_K-1:0][SEL_W-1:0]   in_sel;
        logic [LUT_BITS-1:0]           table_bits;
    } cell_cfg_t;

    function automatic logic pick_source(input src_sel_e s, input logic a, input logic b);
        logic r;
        case (s)
            SRC_LOW:    r = 1'b0;
            SRC_HIGH:   r = 1'b1;
            SRC_CHAN_A: r = a;
            default:    r = b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lut_cell_inmux.sv
module lut_cell_inmux
    import lut_cell_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             chan_a,
    input  logic             chan_b,
    output logic             y
);

    src_sel_e sel_e;

    always_comb begin
        sel_e = src_sel_e'(sel);
        y     = pick_source(sel_e, chan_a, chan_b);
    end

endmodule

// File: rtl/lut_cell_table.sv
module lut_cell_table #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] table_bits,
    input  logic [K-1:0]      addr,
    output logic              q
);

    always_comb q = table_bits[addr];

endmodule

// File: rtl/lut_cell_store.sv
module lut_cell_store (
    input  logic clk,
    input  logic rst,
    input  logic d,
    input  logic rst_from_chan,
    input  logic chan_rst,
    input  logic use_reg,
    output logic cell_out
);

    logic q_r;
    logic clr;

    always_comb clr = rst_from_chan && chan_rst;

    always_ff @(posedge clk) begin
        if (rst)       q_r <= 1'b0;
        else if (clr)  q_r <= 1'b0;
        else           q_r <= d;
    end

    always_comb cell_out = use_reg ? q_r : d;

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !q_r);

    // R5
    chan_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_from_chan && chan_rst) |=> !q_r);

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        !(rst_from_chan && chan_rst) |=> (q_r == $past(d)));

endmodule

// File: rtl/lut_cell_drive.sv
module lut_cell_drive #(
    parameter int N = 4
) (
    input  logic         result,
    input  logic [N-1:0] oe,
    output logic [N-1:0] track_data,
    output logic [N-1:0] track_en
);

    for (genvar t = 0; t < N; t++) begin : g_track
        always_comb begin
            track_en[t]   = oe[t];
            track_data[t] = oe[t] & result;
        end
    end

    // R6
    no_leak_chk: assert final ($countones(track_data & ~track_en) == 0);

endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CFG_W-1:0]    cfg_word,
    input  logic [CHAN_W-1:0]   chan_in,
    input  logic                chan_rst,
    output logic [N_TRACK-1:0]  track_data,
    output logic [N_TRACK-1:0]  track_en
);

    cell_cfg_t        cfg;
    logic [LUT_K-1:0] addr;
    logic             lut_q;
    logic             cell_out;
    logic             unused_rsvd;

    always_comb begin
        cfg         = cell_cfg_t'(cfg_word);
        unused_rsvd = ^cfg.rsvd;
    end

    for (genvar i = 0; i < LUT_K; i++) begin : g_in
        lut_cell_inmux u_mux (
            .sel    (cfg.in_sel[i]),
            .chan_a (chan_in[2*i]),
            .chan_b (chan_in[2*i+1]),
            .y      (addr[i])
        );
    end

    lut_cell_table #(.K(LUT_K)) u_table (
        .table_bits (cfg.table_bits),
        .addr       (addr),
        .q          (lut_q)
    );

    lut_cell_store u_store (
        .clk           (clk),
        .rst           (rst),
        .d             (lut_q),
        .rst_from_chan (cfg.rst_from_chan),
        .chan_rst      (chan_rst),
        .use_reg       (cfg.use_reg),
        .cell_out      (cell_out)
    );

    lut_cell_drive #(.N(N_TRACK)) u_drive (
        .result     (cell_out),
        .oe         (cfg.oe),
        .track_data (track_data),
        .track_en   (track_en)
    );

    // R3
    const_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.in_sel == '0) |-> (lut_q == cfg.table_bits[0]));

    // R3
    all_high_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.in_sel == {LUT_K{SRC_HIGH}}) |-> (lut_q == cfg.table_bits[LUT_BITS-1]));

endmodule

// File: tb/tb_lut_cell.sv
`timescale 1ns/1ps
module tb_lut_cell;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cfg_word;
    logic [7:0]  chan_in;
    logic        chan_rst;
    logic [3:0]  track_data;
    logic [3:0]  track_en;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done   = 0;
    string tag    = "R1";
    logic  ref_q  = 1'b0;

    lut_cell dut (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .chan_in(chan_in),
        .chan_rst(chan_rst), .track_data(track_data), .track_en(track_en)
    );

    always #2.5 clk = ~clk;

    function automatic logic src_val(logic [31:0] c, logic [7:0] ch, int i);
        logic [1:0] s;
        s = c[16+2*i +: 2];
        if (s == 2'd0) return 1'b0;
        if (s == 2'd1) return 1'b1;
        if (s == 2'd2) return ch[2*i];
        return ch[2*i+1];
    endfunction

    function automatic logic model_lut(logic [31:0] c, logic [7:0] ch);
        int idx = 0;
        for (int i = 0; i < 4; i++)
            if (src_val(c, ch, i)) idx += (1 << i);
        return c[idx];
    endfunction

    always @(posedge clk) begin
        if (rst)                        ref_q <= 1'b0;
        else if (cfg_word[25] && chan_rst) ref_q <= 1'b0;
        else                            ref_q <= model_lut(cfg_word, chan_in);
    end

    task automatic step();
        logic       res;
        logic [3:0] exp_en, exp_d;
        @(negedge clk);
        res    = cfg_word[24] ? ref_q : model_lut(cfg_word, chan_in);
        exp_en = cfg_word[29:26];
        exp_d  = exp_en & {4{res}};
        checks++;
        if (track_data !== exp_d) begin
            errors++;
            $display("FAIL %s: track_data=%b expected %b", tag, track_data, exp_d);
        end
        checks++;
        if (track_en !== exp_en) begin
            errors++;
            $display("FAIL %s: track_en=%b expected %b", tag, track_en, exp_en);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000 && !done) begin
                errors++;
                $display("FAIL watchdog: cycles=%0d expected below 50000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst      = 1'b1;
        cfg_word = {2'b00, 4'b1111, 1'b0, 1'b1, 8'b01010101, 16'hFFFF};
        chan_in  = '0;
        chan_rst = 1'b0;

        // R1: registered mode under reset reads 0 even though the table gives 1
        tag = "R1";
        repeat (3) step();
        rst = 1'b0;
        step();

        // R2: sweep every table address via channel-A selectors
        tag = "R2";
        cfg_word = {2'b00, 4'b1111, 1'b0, 1'b0, 8'b10101010, 16'hA5C3};
        for (int a = 0; a < 16; a++) begin
            chan_in = '0;
            for (int i = 0; i < 4; i++) chan_in[2*i] = a[i];
            step();
        end

        // R3: every selector code with random channel values
        tag = "R3";
        for (int n = 0; n < 300; n++) begin
            cfg_word[23:16] = 8'($urandom);
            cfg_word[15:0]  = 16'($urandom);
            chan_in         = 8'($urandom);
            step();
        end

        // R4: registered mode follows table one cycle late
        tag = "R4";
        cfg_word[24] = 1'b1;
        for (int n = 0; n < 200; n++) begin
            cfg_word[23:16] = 8'($urandom);
            chan_in         = 8'($urandom);
            step();
        end

        // R5: channel reset ignored when not selected
        tag = "R5";
        cfg_word = {2'b00, 4'b1111, 1'b0, 1'b1, 8'b01010101, 16'hFFFF};
        chan_rst = 1'b1;
        repeat (3) step();
        cfg_word[25] = 1'b1;
        repeat (3) step();
        for (int n = 0; n < 200; n++) begin
            chan_rst        = 1'($urandom);
            chan_in         = 8'($urandom);
            cfg_word[23:16] = 8'($urandom);
            step();
        end
        chan_rst = 1'b0;

        // R6: every enable pattern, both output modes
        tag = "R6";
        for (int e = 0; e < 32; e++) begin
            cfg_word[29:26] = 4'(e);
            cfg_word[24]    = e[4];
            chan_in         = 8'($urandom);
            step();
            step();
        end

        // R7: reserved bits toggled during random traffic
        tag = "R7";
        for (int n = 0; n < 200; n++) begin
            cfg_word = $urandom;
            chan_rst = 1'($urandom);
            chan_in  = 8'($urandom);
            step();
        end
        chan_rst = 1'b0;

        // R8: two-input AND with random upper table bits
        tag = "R8";
        for (int n = 0; n < 16; n++) begin
            cfg_word = {2'b00, 4'b1111, 1'b0, 1'b0, 2'b00, 2'b00, 2'b11, 2'b10,
                        12'($urandom), 4'b1000};
            chan_in  = 8'($urandom);
            step();
            checks++;
            if (track_data[0] !== (chan_in[0] & chan_in[3])) begin
                errors++;
                $display("FAIL R8: track_data[0]=%b expected %b",
                         track_data[0], chan_in[0] & chan_in[3]);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule